// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This combinational helper sits between a 32-bit RISC-V core's memory stage and its data memory. On the read side it takes the full word that memory returned, the two low address bits of the access and the load's funct3 code. It picks out the addressed byte or halfword and widens it to 32 bits, either copying the sign bit upward or filling with zeros. A word load comes back untouched.

On the write side it takes a store-enable, the store's funct3 code, the same two low address bits and the register value to be written. It produces a four-bit byte-enable vector and a 32-bit write word in which the source bytes sit on the enabled lanes. Lanes that are not enabled carry zero. Misaligned-access detection, the memory array and any bus handshake stay outside the block.

Top module: `lane_align_unit`

## Requirements
- R1: Load code 000 (signed byte) returns the byte at lane `addr_lo`, i.e. bits [8*addr_lo+7 : 8*addr_lo] of `ld_word`, with bit 7 of that byte copied into bits 31:8.
- R2: Load code 100 (unsigned byte) returns the same byte as R1, with bits 31:8 cleared.
- R3: Load code 001 (signed halfword) returns `ld_word[15:0]` when `addr_lo[1]` is 0 and `ld_word[31:16]` when it is 1, with bit 15 of the half copied into bits 31:16. `addr_lo[0]` has no effect on the result.
- R4: Load code 101 (unsigned halfword) returns the same half as R3, with bits 31:16 cleared. `addr_lo[0]` has no effect on the result.
- R5: Load code 010 (word) returns `ld_word` unchanged for every value of `addr_lo`.
- R6: Load codes 011, 110 and 111 return zero.
- R7: With `st_en` high and store code 000 (byte), `st_strb` has exactly one bit set, bit `addr_lo`. That lane of `st_wdata` carries `st_src[7:0]`.
- R8: With `st_en` high and store code 001 (halfword), `st_strb` is 0011 when `addr_lo[1]` is 0 and 1100 when it is 1. The enabled lanes carry `st_src[15:0]`, lower byte on the lower lane. `addr_lo[0]` has no effect.
- R9: With `st_en` high and store code 010 (word), `st_strb` is 1111 and `st_wdata` equals `st_src` for every `addr_lo`.
- R10: When `st_en` is low, or the store code is any value other than 000, 001 or 010, `st_strb` is 0000. Every byte lane of `st_wdata` whose strobe bit is clear is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr_lo | input | 2 | Low two bits of the access address, shared by load and store paths |
| ld_word | input | 32 | Full word read from memory |
| ld_funct3 | input | 3 | Load width and signedness code |
| ld_data | output | 32 | Extracted and extended load result |
| st_en | input | 1 | A store is being issued this cycle |
| st_funct3 | input | 3 | Store width code |
| st_src | input | 32 | Register value to store |
| st_strb | output | 4 | Byte-lane write enables, bit n enables bits [8n+7:8n] |
| st_wdata | output | 32 | Store data steered onto its lanes |

## Verification
The read path and the write path share one address input and both compute from it in the same cycle. A fault in lane decoding can therefore show up in one path while the other still looks right. The bench drives every vector with independent, randomly chosen load and store codes and data over one shared random `addr_lo`. It then checks `ld_data`, `st_strb` and `st_wdata` together against separately computed references, so a mixed load-code/store-code pairing cannot hide a lane error in either path. Directed vectors add the sign-boundary bytes and halves at each lane, odd addresses for half and word accesses, and the undefined codes.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

   typedef enum logic [2:0] {
      LDK_SBYTE = 3'b000,
      LDK_SHALF = 3'b001,
      LDK_WORD  = 3'b010,
      LDK_UBYTE = 3'b100,
      LDK_UHALF = 3'b101
   } load_kind_e;

   typedef enum logic [2:0] {
      STK_BYTE = 3'b000,
      STK_HALF = 3'b001,
      STK_WORD = 3'b010
   } store_kind_e;

endpackage

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen
   import lane_align_pkg::*;
#(
   parameter int OFFS_W = 2
) (
   input  logic              st_en,
   input  logic [2:0]        code,
   input  logic [OFFS_W-1:0] offs,
   output logic [OFFS_W-1:0] span_mask,
   output logic [(1<<OFFS_W)-1:0] strobe
);
   localparam int LANES = 1 << OFFS_W;

   logic active;

   always_comb begin
      active    = st_en;
      span_mask = '0;
      case (code)
         STK_BYTE: span_mask = '0;
         STK_HALF: span_mask = OFFS_W'(1);
         STK_WORD: span_mask = '1;
         default:  active = 1'b0;
      endcase
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [OFFS_W-1:0] LANE_ID = OFFS_W'(g);
      assign strobe[g] = active && ((LANE_ID & ~span_mask) == (offs & ~span_mask));
   end

endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer #(
   parameter int XLEN   = 32,
   parameter int LANE_W = 8,
   parameter int OFFS_W = 2
) (
   input  logic [XLEN-1:0]        src,
   input  logic [OFFS_W-1:0]      span_mask,
   input  logic [(1<<OFFS_W)-1:0] strobe,
   output logic [XLEN-1:0]        wdata
);
   localparam int LANES = 1 << OFFS_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam logic [OFFS_W-1:0] LANE_ID = OFFS_W'(g);
      logic [OFFS_W-1:0] pick;
      assign pick = LANE_ID & span_mask;
      assign wdata[g*LANE_W +: LANE_W] = strobe[g] ? src[LANE_W*pick +: LANE_W] : '0;
   end

endmodule

// File: rtl/lane_load_extend.sv
module lane_load_extend
   import lane_align_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int LANE_W = 8,
   parameter int OFFS_W = 2
) (
   input  logic [XLEN-1:0]   rd_word,
   input  logic [2:0]        code,
   input  logic [OFFS_W-1:0] offs,
   output logic [XLEN-1:0]   result
);
   localparam int HALF_W = 2 * LANE_W;

   logic [LANE_W-1:0] byte_v;
   logic [HALF_W-1:0] half_v;

   assign byte_v = rd_word[LANE_W*offs +: LANE_W];
   assign half_v = rd_word[HALF_W*offs[OFFS_W-1] +: HALF_W];

   always_comb begin
      case (code)
         LDK_SBYTE: result = {{(XLEN-LANE_W){byte_v[LANE_W-1]}}, byte_v};
         LDK_UBYTE: result = {{(XLEN-LANE_W){1'b0}}, byte_v};
         LDK_SHALF: result = {{(XLEN-HALF_W){half_v[HALF_W-1]}}, half_v};
         LDK_UHALF: result = {{(XLEN-HALF_W){1'b0}}, half_v};
         LDK_WORD:  result = rd_word;
         default:   result = '0;
      endcase
   end

endmodule

// File: rtl/lane_align_unit.sv
module lane_align_unit #(
   parameter int XLEN   = 32,
   parameter int LANE_W = 8
) (
   input  logic [1:0]  addr_lo,
   input  logic [31:0] ld_word,
   input  logic [2:0]  ld_funct3,
   output logic [31:0] ld_data,
   input  logic        st_en,
   input  logic [2:0]  st_funct3,
   input  logic [31:0] st_src,
   output logic [3:0]  st_strb,
   output logic [31:0] st_wdata
);
   localparam int LANES  = XLEN / LANE_W;
   localparam int OFFS_W = $clog2(LANES);

   if (XLEN != 32) begin : g_bad_xlen
      $error("lane_align_unit: XLEN must be 32");
   end
   if (LANE_W != 8) begin : g_bad_lane
      $error("lane_align_unit: LANE_W must be 8");
   end

   logic [OFFS_W-1:0] span_mask;

   lane_load_extend #(.XLEN(XLEN), .LANE_W(LANE_W), .OFFS_W(OFFS_W)) u_load (
      .rd_word (ld_word),
      .code    (ld_funct3),
      .offs    (addr_lo),
      .result  (ld_data)
   );

   lane_strobe_gen #(.OFFS_W(OFFS_W)) u_strobe (
      .st_en     (st_en),
      .code      (st_funct3),
      .offs      (addr_lo),
      .span_mask (span_mask),
      .strobe    (st_strb)
   );

   lane_store_steer #(.XLEN(XLEN), .LANE_W(LANE_W), .OFFS_W(OFFS_W)) u_steer (
      .src       (st_src),
      .span_mask (span_mask),
      .strobe    (st_strb),
      .wdata     (st_wdata)
   );

endmodule

// File: rtl/lane_align_checker.sv
module lane_align_checker (
   input logic [1:0]  addr_lo,
   input logic [31:0] ld_word,
   input logic [2:0]  ld_funct3,
   input logic [31:0] ld_data,
   input logic        st_en,
   input logic [2:0]  st_funct3,
   input logic [31:0] st_src,
   input logic [3:0]  st_strb,
   input logic [31:0] st_wdata
);
   logic known;
   assign known = !$isunknown({addr_lo, ld_word, ld_funct3, st_en, st_funct3, st_src});

   always_comb begin
      if (known) begin
         if (!st_en)
            AST_STRB_IDLE: assert (st_strb == 4'b0000); // R10
         if (st_en && st_funct3 == 3'b000)
            AST_STRB_ONE_LANE: assert ($countones(st_strb) == 1); // R7
         if (st_en && st_funct3 == 3'b001)
            AST_STRB_HALF_PAIR: assert (st_strb == 4'b0011 || st_strb == 4'b1100); // R8
         if (st_en && st_funct3 == 3'b010)
            AST_WORD_STORE_PASS: assert (st_strb == 4'b1111 && st_wdata == st_src); // R9
         for (int i = 0; i < 4; i++)
            if (!st_strb[i])
               AST_WDATA_DEAD_LANE: assert (st_wdata[8*i +: 8] == 8'h00); // R10
         if (ld_funct3 == 3'b010)
            AST_LOAD_WORD_PASS: assert (ld_data == ld_word); // R5
         if (ld_funct3 == 3'b100)
            AST_UBYTE_HIGH_ZERO: assert (ld_data[31:8] == 24'h0); // R2
         if (ld_funct3 == 3'b101)
            AST_UHALF_HIGH_ZERO: assert (ld_data[31:16] == 16'h0); // R4
      end
   end

endmodule

bind lane_align_unit lane_align_checker u_lane_align_checker (
   .addr_lo   (addr_lo),
   .ld_word   (ld_word),
   .ld_funct3 (ld_funct3),
   .ld_data   (ld_data),
   .st_en     (st_en),
   .st_funct3 (st_funct3),
   .st_src    (st_src),
   .st_strb   (st_strb),
   .st_wdata  (st_wdata)
);

// File: tb/test_lane_align_unit.sv
module test_lane_align_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [1:0]  addr_lo = '0;
   logic [31:0] ld_word = '0;
   logic [2:0]  ld_funct3 = 3'b111;
   logic [31:0] ld_data;
   logic        st_en = 1'b0;
   logic [2:0]  st_funct3 = '0;
   logic [31:0] st_src = '0;
   logic [3:0]  st_strb;
   logic [31:0] st_wdata;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   lane_align_unit i_lane_align_unit (
      .addr_lo, .ld_word, .ld_funct3, .ld_data,
      .st_en, .st_funct3, .st_src, .st_strb, .st_wdata
   );

   function automatic logic [31:0] ref_load(logic [31:0] w, logic [2:0] f, logic [1:0] a);
      logic [7:0]  b;
      logic [15:0] h;
      b = 8'(w >> (8 * a));
      h = a[1] ? w[31:16] : w[15:0];
      case (f)
         3'b000:  return {{24{b[7]}}, b};
         3'b100:  return {24'h0, b};
         3'b001:  return {{16{h[15]}}, h};
         3'b101:  return {16'h0, h};
         3'b010:  return w;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [3:0] ref_strb(logic en, logic [2:0] f, logic [1:0] a);
      if (!en) return 4'b0000;
      case (f)
         3'b000:  return 4'b0001 << a;
         3'b001:  return a[1] ? 4'b1100 : 4'b0011;
         3'b010:  return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic logic [31:0] ref_wdata(logic en, logic [2:0] f, logic [1:0] a, logic [31:0] d);
      logic [3:0]  s;
      logic [31:0] full;
      logic [31:0] keep;
      s = ref_strb(en, f, a);
      case (f)
         3'b000:  full = {4{d[7:0]}};
         3'b001:  full = {2{d[15:0]}};
         default: full = d;
      endcase
      keep = {{8{s[3]}}, {8{s[2]}}, {8{s[1]}}, {8{s[0]}}};
      return full & keep;
   endfunction

   function automatic string load_tag(logic [2:0] f);
      case (f)
         3'b000:  return "R1";
         3'b100:  return "R2";
         3'b001:  return "R3";
         3'b101:  return "R4";
         3'b010:  return "R5";
         default: return "R6";
      endcase
   endfunction

   function automatic string store_tag(logic en, logic [2:0] f);
      if (!en) return "R10";
      case (f)
         3'b000:  return "R7";
         3'b001:  return "R8";
         3'b010:  return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic compare(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] w, logic [2:0] lf, logic [1:0] a,
                        logic en, logic [2:0] sf, logic [31:0] d);
      @(negedge clk);
      ld_word = w; ld_funct3 = lf; addr_lo = a;
      st_en = en; st_funct3 = sf; st_src = d;
      #1;
      compare(load_tag(lf), "ld_data", ld_data, ref_load(w, lf, a));
      compare(store_tag(en, sf), "st_strb", {28'h0, st_strb}, {28'h0, ref_strb(en, sf, a)});
      compare(store_tag(en, sf), "st_wdata", st_wdata, ref_wdata(en, sf, a, d));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      int unsigned seed_init;
      seed_init = $urandom(32'd2718);
      repeat (3) @(posedge clk);
      // reset state: idle store (R10), undefined load code (R6)
      #1;
      compare("R10", "reset st_strb", {28'h0, st_strb}, 32'h0);
      compare("R10", "reset st_wdata", st_wdata, 32'h0);
      compare("R6", "reset ld_data", ld_data, 32'h0);
      rst_n = 1'b1;

      // R1 / R2: sign boundary byte at every lane
      for (int a = 0; a < 4; a++) begin
         apply(32'h7F80_807F << 0, 3'b000, 2'(a), 1'b1, 3'b000, 32'hA5A5_A5C3); // R1 R7
         apply(32'h8080_8080, 3'b100, 2'(a), 1'b1, 3'b001, 32'h1234_89AB);      // R2 R8
      end
      // R3 / R4: halves with odd offsets (bit 0 ignored)
      apply(32'h8000_7FFF, 3'b001, 2'd3, 1'b1, 3'b010, 32'hDEAD_BEEF); // R3 R9
      apply(32'h8000_7FFF, 3'b001, 2'd1, 1'b1, 3'b001, 32'hCAFE_F00D); // R3 R8
      apply(32'hFFFF_8001, 3'b101, 2'd1, 1'b1, 3'b001, 32'h0000_8001); // R4 R8
      apply(32'hFFFF_8001, 3'b101, 2'd3, 1'b0, 3'b001, 32'hFFFF_FFFF); // R4 R10
      // R5: word load ignores both offset bits
      apply(32'h89AB_CDEF, 3'b010, 2'd3, 1'b1, 3'b010, 32'h0102_0304); // R5 R9
      // R6: undefined load codes; R10: undefined store codes
      apply(32'hFFFF_FFFF, 3'b011, 2'd0, 1'b1, 3'b011, 32'hFFFF_FFFF);
      apply(32'hFFFF_FFFF, 3'b110, 2'd2, 1'b1, 3'b111, 32'hFFFF_FFFF);
      apply(32'hFFFF_FFFF, 3'b111, 2'd1, 1'b1, 3'b100, 32'hFFFF_FFFF);
      apply(32'h1357_9BDF, 3'b000, 2'd2, 1'b0, 3'b000, 32'hFFFF_FFFF); // R10 idle

      // mixed random: both paths active on a shared offset
      for (int n = 0; n < 3000; n++) begin
         logic [2:0] lf;
         logic [2:0] sf;
         lf = 3'($urandom_range(0, 7));
         sf = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(3, 7)) : 3'($urandom_range(0, 2));
         apply($urandom, lf, 2'($urandom), ($urandom_range(0, 5) != 0), sf, $urandom);
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule